// File: doc/BRIEF.md
# Single-precision floating-point square root

This block takes one IEEE-754 binary32 operand and returns its square root, correctly rounded to nearest, as a binary32 result. It splits the operand into its fields and restores the hidden leading one. It widens the mantissa so that the integer root carries two extra low bits. When the unbiased exponent is odd it doubles the mantissa and lowers the exponent by one, so that the exponent can be halved exactly.

The root itself comes from an iterative non-restoring integer square root that produces one root bit per clock. The two extra low root bits decide the rounding. A carry out of the rounding step moves into the exponent. The result is then packed back into binary32 form.

The special values (NaN, infinities, zeros and negative operands) travel through the same path with the same latency, so the caller always sees one result per accepted operand at a fixed distance. Subnormal operands count as zero. Only round-to-nearest is provided, and no exception flags are raised.

Top module: `fp32_sqrt_seq`

## Requirements
- R1: The operand is read as sign = bit 31, biased exponent E = bits 30:23 (bias 127) and fraction = bits 22:0. For a positive normal operand (1 <= E <= 254) the result has sign 0 and biased exponent (E+127)>>1, plus one when rounding carries out of the 24-bit mantissa.
- R2: For a positive normal operand, the result fraction is the exact square root rounded to the nearest binary32 value.
- R3: Perfect squares give exact results: 4.0 (0x40800000) gives 2.0 (0x40000000), 16.0 (0x41800000) gives 4.0 (0x40800000), and 65536.0 (0x47800000) gives 256.0 (0x43800000).
- R4: A NaN operand (E = 255, fraction nonzero), negative infinity, or any negative operand with E in 1..254 gives the quiet NaN 0x7FC00000.
- R5: Positive infinity (0x7F800000) gives positive infinity (0x7F800000).
- R6: An operand with E = 0 (zero or subnormal) gives a zero with the operand's sign: 0x00000000 for sign 0, 0x80000000 for sign 1.
- R7: `out_valid` is high for exactly one cycle per accepted operand. That cycle follows the 27th rising edge after the edge that accepted the operand, and `out_result` is valid during it.
- R8: While an operand is being worked on, `in_valid` is ignored and produces no extra output and no change to the pending result. A new operand can be accepted from the cycle in which `out_valid` is high onward.
- R9: After reset, `out_valid` is 0 and `out_result` is 0x00000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operand present; taken only while the unit is idle |
| in_operand | input | 32 | binary32 operand |
| out_valid | output | 1 | One-cycle pulse marking a finished result |
| out_result | output | 32 | binary32 square root, held until the next result |

## Verification
A wrong iteration count or a wrong remainder sign decision in the root core corrupts the mantissa. This shows up in `out_result` at the very next `out_valid` pulse, 27 cycles after the operand was taken. A bad rounding decision shows up as a one-ulp error on random operands. A wrong odd-exponent adjustment shows up as a root off by a factor near the square root of two. A busy flag stuck low or high shows up at once as a missing pulse, a second pulse, or a result that belongs to the wrong operand.

// File: rtl/fsqrt_pkg.sv
// Package: shared types for the binary32 square-root unit.
// Assumes: the operand classes below cover all input encodings.
package fsqrt_pkg;

    // Class of the operand, decides which result path is packed
    typedef enum logic [1:0] {
        CLS_NORMAL = 2'd0,
        CLS_ZERO   = 2'd1,
        CLS_INF    = 2'd2,
        CLS_NAN    = 2'd3
    } fsqrt_cls_e;

endpackage

// File: rtl/fsqrt_unpack.sv
// Module: fsqrt_unpack
// Splits a floating-point operand into its fields and classifies it.
// Builds the widened radicand for the integer root and computes the
// halved result exponent, including the odd-exponent adjustment.
// Assumes: purely combinational; subnormals are classed as zero.
module fsqrt_unpack
    import fsqrt_pkg::*;
#(
    parameter int EXP_W   = 8,
    parameter int FRAC_W  = 23,
    parameter int GUARD_W = 2
) (
    input  logic [EXP_W+FRAC_W:0]             operand,
    output fsqrt_cls_e                        cls,
    output logic                              sign,
    output logic [EXP_W-1:0]                  res_exp,
    output logic [2*(FRAC_W+1+GUARD_W)-1:0]   radicand
);
    localparam int MANT_W = FRAC_W + 1;
    localparam int ROOT_W = MANT_W + GUARD_W;
    localparam int RAD_W  = 2 * ROOT_W;
    localparam int PRE_SH = RAD_W - MANT_W - 1;
    localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
    localparam int SE_W   = EXP_W + 2;

    logic [EXP_W-1:0]        f_exp;
    logic [FRAC_W-1:0]       f_frac;
    logic signed [SE_W-1:0]  exp_unb;
    logic signed [SE_W-1:0]  exp_adj;
    logic signed [SE_W-1:0]  exp_half;
    logic                    exp_odd;
    logic [RAD_W-1:0]        mant_wide;

    // Field extraction
    assign sign   = operand[EXP_W+FRAC_W];
    assign f_exp  = operand[EXP_W+FRAC_W-1:FRAC_W];
    assign f_frac = operand[FRAC_W-1:0];

    // Operand classification
    always_comb begin
        if (&f_exp) begin
            if (f_frac != '0)  cls = CLS_NAN;
            else if (sign)     cls = CLS_NAN;
            else               cls = CLS_INF;
        end else if (f_exp == '0) begin
            cls = CLS_ZERO;
        end else if (sign) begin
            cls = CLS_NAN;
        end else begin
            cls = CLS_NORMAL;
        end
    end

    // Unbiased exponent, odd adjustment and arithmetic halving
    always_comb begin
        exp_unb  = $signed({2'b00, f_exp}) - SE_W'(BIAS);
        exp_odd  = exp_unb[0];
        exp_adj  = exp_unb - SE_W'(exp_odd);
        exp_half = exp_adj >>> 1;
        res_exp  = EXP_W'(exp_half + SE_W'(BIAS));
    end

    // Radicand: hidden one restored, widened, one extra bit for odd exponents
    always_comb begin
        mant_wide = {{(RAD_W-MANT_W){1'b0}}, 1'b1, f_frac};
        radicand  = exp_odd ? (mant_wide << (PRE_SH + 1)) : (mant_wide << PRE_SH);
    end

endmodule

// File: rtl/fsqrt_root_core.sv
// Module: fsqrt_root_core
// Iterative non-restoring integer square root, one root bit per clock.
// A start pulse loads the radicand; after ROOT_W iterations a done pulse
// marks a valid root, which stays held until the next start.
// Assumes: start is only raised while the core is idle.
module fsqrt_root_core #(
    parameter int ROOT_W = 26
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [2*ROOT_W-1:0]   radicand,
    output logic                  done,
    output logic [ROOT_W-1:0]     root
);
    localparam int RAD_W = 2 * ROOT_W;
    localparam int REM_W = ROOT_W + 4;
    localparam int CNT_W = $clog2(ROOT_W + 1);

    logic [RAD_W-1:0]  rad_q;
    logic [REM_W-1:0]  rem_q;
    logic [ROOT_W-1:0] root_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              done_q;

    logic [REM_W-1:0]  rem_sh;
    logic [REM_W-1:0]  rem_nx;
    logic              bit_nx;

    // One non-restoring step: add or subtract the trial term by remainder sign
    always_comb begin
        rem_sh = {rem_q[REM_W-3:0], rad_q[RAD_W-1 -: 2]};
        if (rem_q[REM_W-1])
            rem_nx = rem_sh + {2'b00, root_q, 2'b11};
        else
            rem_nx = rem_sh - {2'b00, root_q, 2'b01};
        bit_nx = ~rem_nx[REM_W-1];
    end

    // Iteration registers and done pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rad_q  <= '0;
            rem_q  <= '0;
            root_q <= '0;
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start) begin
                rad_q  <= radicand;
                rem_q  <= '0;
                root_q <= '0;
                cnt_q  <= CNT_W'(ROOT_W);
            end else if (cnt_q != '0) begin
                rad_q  <= {rad_q[RAD_W-3:0], 2'b00};
                rem_q  <= rem_nx;
                root_q <= {root_q[ROOT_W-2:0], bit_nx};
                cnt_q  <= cnt_q - 1'b1;
                if (cnt_q == CNT_W'(1)) done_q <= 1'b1;
            end
        end
    end

    assign done = done_q;
    assign root = root_q;

    // R7: the done pulse lasts a single cycle
    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: done only when the iteration count has run out
    assert_done_at_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cnt_q == '0));

    // R7: the iteration counter never exceeds the root width
    assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(ROOT_W));

endmodule

// File: rtl/fsqrt_pack.sv
// Module: fsqrt_pack
// Rounds the integer root to nearest using its guard bits, folds a rounding
// carry into the exponent and packs the final floating-point word. Special
// classes bypass the root and take their fixed encodings.
// Assumes: purely combinational; for normal operands the root MSB is set.
module fsqrt_pack
    import fsqrt_pkg::*;
#(
    parameter int EXP_W   = 8,
    parameter int FRAC_W  = 23,
    parameter int GUARD_W = 2
) (
    input  fsqrt_cls_e                        cls,
    input  logic                              sign,
    input  logic [EXP_W-1:0]                  res_exp,
    input  logic [FRAC_W+GUARD_W:0]           root,
    output logic [EXP_W+FRAC_W:0]             result
);
    localparam int MANT_W = FRAC_W + 1;
    localparam int ROOT_W = MANT_W + GUARD_W;

    logic [MANT_W:0]    mant_rnd;
    logic               rnd_carry;
    logic [EXP_W-1:0]   exp_out;
    logic [FRAC_W-1:0]  frac_out;

    // Round to nearest: increment when the upper guard bit is set
    always_comb begin
        mant_rnd  = {1'b0, root[ROOT_W-1:GUARD_W]} + (MANT_W+1)'(root[GUARD_W-1]);
        rnd_carry = mant_rnd[MANT_W];
        exp_out   = res_exp + EXP_W'(rnd_carry);
        frac_out  = rnd_carry ? '0 : mant_rnd[FRAC_W-1:0];
    end

    // Final encoding selected by operand class
    always_comb begin
        unique case (cls)
            CLS_NORMAL: result = {1'b0, exp_out, frac_out};
            CLS_ZERO:   result = {sign, {(EXP_W+FRAC_W){1'b0}}};
            CLS_INF:    result = {1'b0, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
            default:    result = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
        endcase
    end

endmodule

// File: rtl/fp32_sqrt_seq.sv
// Module: fp32_sqrt_seq (top)
// Sequential binary32 square root. Accepts an operand when idle, runs the
// iterative root core, then registers the rounded and packed result with a
// one-cycle out_valid pulse. Fixed latency for every operand class.
// Assumes: in_valid during a busy period is dropped.
module fp32_sqrt_seq
    import fsqrt_pkg::*;
#(
    parameter int EXP_W   = 8,
    parameter int FRAC_W  = 23,
    parameter int GUARD_W = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic [EXP_W+FRAC_W:0]  in_operand,
    output logic                   out_valid,
    output logic [EXP_W+FRAC_W:0]  out_result
);
    localparam int OP_W   = 1 + EXP_W + FRAC_W;
    localparam int ROOT_W = FRAC_W + 1 + GUARD_W;
    localparam int RAD_W  = 2 * ROOT_W;

    fsqrt_cls_e          un_cls;
    logic                un_sign;
    logic [EXP_W-1:0]    un_exp;
    logic [RAD_W-1:0]    un_rad;

    fsqrt_cls_e          cls_q;
    logic                sign_q;
    logic [EXP_W-1:0]    exp_q;
    logic                busy_q;
    logic                out_valid_q;
    logic [OP_W-1:0]     out_result_q;

    logic                accept;
    logic                core_done;
    logic [ROOT_W-1:0]   core_root;
    logic [OP_W-1:0]     packed_word;

    assign accept = in_valid && !busy_q;

    fsqrt_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .GUARD_W(GUARD_W)) u_unpack (
        .operand  (in_operand),
        .cls      (un_cls),
        .sign     (un_sign),
        .res_exp  (un_exp),
        .radicand (un_rad)
    );

    fsqrt_root_core #(.ROOT_W(ROOT_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (accept),
        .radicand (un_rad),
        .done     (core_done),
        .root     (core_root)
    );

    fsqrt_pack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .GUARD_W(GUARD_W)) u_pack (
        .cls     (cls_q),
        .sign    (sign_q),
        .res_exp (exp_q),
        .root    (core_root),
        .result  (packed_word)
    );

    // Capture operand attributes and track the busy period
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cls_q  <= CLS_ZERO;
            sign_q <= 1'b0;
            exp_q  <= '0;
        end else if (accept) begin
            busy_q <= 1'b1;
            cls_q  <= un_cls;
            sign_q <= un_sign;
            exp_q  <= un_exp;
        end else if (core_done) begin
            busy_q <= 1'b0;
        end
    end

    // Register the packed result and its valid pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid_q  <= 1'b0;
            out_result_q <= '0;
        end else begin
            out_valid_q <= core_done;
            if (core_done) out_result_q <= packed_word;
        end
    end

    assign out_valid  = out_valid_q;
    assign out_result = out_result_q;

    // R7: out_valid is a single-cycle pulse
    assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    // R8: a result only appears at the end of a busy period
    assert_valid_after_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(busy_q));

    // R8: an operand offered while busy does not end the busy period
    assert_busy_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !core_done) |=> busy_q);

    // R2: a normal operand leaves a root with its top bit set
    assert_root_normalised_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (core_done && cls_q == CLS_NORMAL) |-> core_root[ROOT_W-1]);

    // R1: every finite nonzero result is positive with an in-range exponent
    assert_normal_sign_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_result[OP_W-2:FRAC_W] != '1 && out_result[OP_W-2:0] != '0)
            |-> (!out_result[OP_W-1] && out_result[OP_W-2:FRAC_W] != '0));

endmodule

// File: tb/fp32_sqrt_seq_tb.sv
module fp32_sqrt_seq_tb;

    localparam int LAT = 27;

    logic        clk;
    logic        rst_n;
    logic        in_valid;
    logic [31:0] in_operand;
    logic        out_valid;
    logic [31:0] out_result;

    int n_checks = 0;
    int n_bad    = 0;
    int cycles   = 0;

    fp32_sqrt_seq u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_operand (in_operand),
        .out_valid  (out_valid),
        .out_result (out_result)
    );

    initial clk = 1'b0;
    always #2 clk = ~clk;

    // Watchdog
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            n_checks = n_checks + 1;
            n_bad    = n_bad + 1;
            $display("FAIL watchdog: actual=%0d cycles expected=<150000", cycles);
            $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_checks = n_checks + 1;
        if (got !== exp) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: actual=%08h expected=%08h", req, got, exp);
        end
    endtask

    // Floor integer square root by bit-wise trial squaring
    function automatic logic [63:0] int_root(input logic [63:0] n);
        logic [63:0] r = 0;
        for (int b = 27; b >= 0; b--) begin
            logic [63:0] c = r | (64'd1 << b);
            if (c * c <= n) r = c;
        end
        return r;
    endfunction

    // Reference square root from the requirements
    function automatic logic [31:0] ref_sqrt(input logic [31:0] x);
        logic        s = x[31];
        logic [7:0]  e = x[30:23];
        logic [22:0] f = x[22:0];
        logic [63:0] m, rad, q, r, t;
        logic [8:0]  re;
        if (e == 8'hFF) return (f != 0 || s) ? 32'h7FC00000 : 32'h7F800000;   // R4 R5
        if (e == 8'h00) return {s, 31'b0};                                       // R6
        if (s) return 32'h7FC00000;                                              // R4
        m   = {40'b0, 1'b1, f};
        rad = e[0] ? (m << 27) : (m << 28);
        q   = int_root(rad);
        r   = q >> 2;
        t   = 4 * r + 2;
        if (rad >= t * t) r = r + 1;
        re  = (9'(e) + 9'd127) >> 1;
        if (r[24]) begin
            re = re + 1;
            r  = r >> 1;
        end
        return {1'b0, re[7:0], r[22:0]};
    endfunction

    // Issue one operand at the current negedge, measure latency, check result
    task automatic run_op(input logic [31:0] op, input logic [31:0] exp, input string req);
        int lat = 0;
        in_valid   = 1'b1;
        in_operand = op;
        @(negedge clk);
        in_valid   = 1'b0;
        in_operand = $urandom;
        while (!out_valid && lat < 100) begin
            @(negedge clk);
            lat = lat + 1;
        end
        check("R7 latency", 32'(lat), 32'(LAT));
        check(req, out_result, exp);
    endtask

    initial begin
        void'($urandom(32'h1357_2468));
        rst_n      = 1'b0;
        in_valid   = 1'b0;
        in_operand = '0;
        repeat (3) @(negedge clk);
        check("R9 reset valid", 32'(out_valid), 32'd0);
        check("R9 reset result", out_result, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // Exact squares (R3)
        run_op(32'h41800000, 32'h40800000, "R3 sqrt 16");
        run_op(32'h47800000, 32'h43800000, "R3 sqrt 65536");
        run_op(32'h40800000, 32'h40000000, "R3 sqrt 4");
        run_op(32'h3F800000, 32'h3F800000, "R3 sqrt 1");
        // Rounded values (R1 R2)
        run_op(32'h40000000, 32'h3FB504F3, "R2 sqrt 2");
        run_op(32'h7F7FFFFF, ref_sqrt(32'h7F7FFFFF), "R1 max finite");
        run_op(32'h00800000, ref_sqrt(32'h00800000), "R1 min normal");
        run_op(32'h407FFFFF, ref_sqrt(32'h407FFFFF), "R2 just below 4");
        // Specials (R4 R5 R6)
        run_op(32'h7FC00001, 32'h7FC00000, "R4 nan in");
        run_op(32'hFF800000, 32'h7FC00000, "R4 neg inf");
        run_op(32'hBF800000, 32'h7FC00000, "R4 neg one");
        run_op(32'h7F800000, 32'h7F800000, "R5 pos inf");
        run_op(32'h00000000, 32'h00000000, "R6 pos zero");
        run_op(32'h80000000, 32'h80000000, "R6 neg zero");
        run_op(32'h00000001, 32'h00000000, "R6 pos subnormal");
        run_op(32'h80400000, 32'h80000000, "R6 neg subnormal");

        // R8: second operand offered while busy is ignored
        begin
            int lat = 0;
            int extra = 0;
            in_valid   = 1'b1;
            in_operand = 32'h41C80000;          // 25.0
            @(negedge clk);
            in_valid = 1'b0;
            repeat (4) begin
                @(negedge clk);
                lat = lat + 1;
            end
            in_valid   = 1'b1;
            in_operand = 32'h42C80000;          // 100.0, must be dropped
            @(negedge clk);
            lat = lat + 1;
            in_valid = 1'b0;
            while (!out_valid && lat < 100) begin
                @(negedge clk);
                lat = lat + 1;
            end
            check("R8 busy latency", 32'(lat), 32'(LAT));
            check("R8 busy result", out_result, 32'h40A00000);
            repeat (40) begin
                @(negedge clk);
                if (out_valid) extra = extra + 1;
            end
            check("R8 no extra pulse", 32'(extra), 32'd0);
            check("R8 result held", out_result, 32'h40A00000);
        end

        // Random operands, back to back from the out_valid cycle (R1 R2 R8)
        for (int i = 0; i < 400; i++) begin
            logic [31:0] op = $urandom;
            if (i % 3 != 0) begin
                op[31] = 1'b0;
                if (op[30:23] == 8'h00 || op[30:23] == 8'hFF) op[30:23] = 8'h80;
            end
            run_op(op, ref_sqrt(op), "R2 random");
        end

        $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

endmodule